// File: doc/BRIEF.md
# Timer Interrupt Line Router

This block collects interrupt requests from a set of timer channels and from two external legacy timer sources, and places them on a vector of interrupt lines. Each channel provides a fire request, a line number, an enable and a type bit that selects level or edge signalling. A level channel sets its status bit and holds its line high until software clears the bit by writing a one to it. An edge channel produces a one-cycle pulse on its line and leaves its status bit alone.

A global enable gates every channel. A legacy-replacement control moves channel 0 onto line 0 and channel 1 onto line 8. In that mode the external periodic-tick source and the real-time-clock source are blocked from those lines, and the PIT-enable output asks the external tick timer to stop. The block always records the current real-time-clock level, so that line 8 can be restored when the mode is left. All state is registered. Outputs change one clock after the inputs that cause them.

Top module: `irq_route_unit`

## Requirements
- R1: After reset every interrupt line is low, every status bit is 0, `pit_en` is 1 and the recorded RTC level is 0.
- R2: A fire request on an enabled level channel (type bit 1) while `glb_en` is 1 sets that channel's status bit. One cycle later its line is high, and the line stays high while the bit stays set.
- R3: A fire request on an enabled edge channel (type bit 0) while `glb_en` is 1 raises its line for exactly one cycle and does not change its status bit.
- R4: A fire request on a channel whose own enable or `glb_en` is 0 clears that channel's status bit and does not raise its line.
- R5: When `sts_clr_we` is 1, each channel whose bit in `sts_clr_data` is 1 has its status bit cleared and its line contribution removed. Bits written as 0 have no effect. A clear wins over a fire request on the same channel in the same cycle.
- R6: While legacy mode is active, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. Every other channel, and every channel outside legacy mode, drives the line numbered by its route field.
- R7: Outside legacy mode, `pit_irq_in` appears on line 0 and `rtc_irq_in` appears on line 8 one cycle later. In legacy mode neither input reaches a line.
- R8: In the first cycle of legacy mode, lines 0 and 8 are low and `pit_en` is 0. `pit_en` stays 0 for as long as the mode lasts.
- R9: In the first cycle after legacy mode ends, line 0 is low, `pit_en` is 1 and line 8 equals the RTC level recorded during legacy mode.
- R10: A line is the OR of every source routed to it, so channels and legacy inputs can share a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fire_req | input | NUM_CH | Per-channel fire request, one cycle per event |
| ch_route | input | NUM_CH*ROUTE_W | Per-channel target line number, channel c in bits [c*ROUTE_W +: ROUTE_W] |
| ch_level | input | NUM_CH | 1 = level type, 0 = edge type |
| ch_en | input | NUM_CH | Per-channel interrupt enable |
| glb_en | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Legacy-replacement mode request |
| pit_irq_in | input | 1 | External periodic-tick interrupt level |
| rtc_irq_in | input | 1 | External real-time-clock interrupt level |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_data | input | NUM_CH | Write-one-to-clear mask for the status bits |
| irq_lines | output | NUM_LINES | Interrupt line vector |
| pit_en | output | 1 | 1 while the external tick timer may run |
| irq_status | output | NUM_CH | Level-channel status bits |

## Verification
On every cycle the assertions check the per-channel rules: a level fire sets the status bit, a disabled fire or a clear empties the channel, and an edge pulse never outlives its fire. They also check the line values in the first cycle after each legacy-mode transition. Only the bench's scenarios can show the full routing picture. This covers the swap of channels 0 and 1 onto lines 0 and 8, the blocking and restoring of the external sources, the OR sharing of one line, and the recorded RTC level surviving a legacy period in which it changed.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int LINE_TICK = 0;
   localparam int LINE_RTC  = 8;
   localparam int MIN_LINES = LINE_RTC + 1;
   localparam int MIN_CH    = 2;
endpackage

// File: rtl/irq_chan_slot.sv
module irq_chan_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic ch_en,
   input  logic glb_en,
   input  logic is_level,
   input  logic clr,
   output logic held,
   output logic pulse
);
   logic accept;
   assign accept = fire & ch_en & glb_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= 1'b0;
         pulse <= 1'b0;
      end else begin
         if (clr)
            held <= 1'b0;
         else if (fire && !accept)
            held <= 1'b0;
         else if (accept && is_level)
            held <= 1'b1;
         pulse <= accept & ~is_level & ~clr;
      end
   end

   p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire && ch_en && glb_en && is_level && !clr |=> held);
   p_disabled_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !(ch_en && glb_en) |=> !held && !pulse);
   p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !held && !pulse);
   p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse || $past(fire && ch_en && glb_en));
endmodule

// File: rtl/irq_legacy_ctl.sv
module irq_legacy_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic legacy_mode,
   input  logic pit_irq_in,
   input  logic rtc_irq_in,
   output logic legacy_q,
   output logic enter_q,
   output logic exit_q,
   output logic tick_q,
   output logic rtc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         legacy_q <= 1'b0;
         enter_q  <= 1'b0;
         exit_q   <= 1'b0;
         tick_q   <= 1'b0;
         rtc_q    <= 1'b0;
      end else begin
         enter_q  <= legacy_mode & ~legacy_q;
         exit_q   <= ~legacy_mode & legacy_q;
         legacy_q <= legacy_mode;
         tick_q   <= pit_irq_in;
         rtc_q    <= rtc_irq_in;
      end
   end
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
   parameter int NUM_CH    = 4,
   parameter int NUM_LINES = 16,
   parameter int ROUTE_W   = 4
) (
   input  logic [NUM_CH-1:0]         act,
   input  logic [NUM_CH*ROUTE_W-1:0] route,
   input  logic                      legacy_q,
   input  logic                      enter_q,
   input  logic                      exit_q,
   input  logic                      tick_q,
   input  logic                      rtc_q,
   output logic [NUM_LINES-1:0]      lines
);
   import irq_route_pkg::*;

   logic [ROUTE_W-1:0] eff [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_eff
      if (c == 0) begin : g_c0
         assign eff[c] = legacy_q ? ROUTE_W'(LINE_TICK) : route[c*ROUTE_W +: ROUTE_W];
      end else if (c == 1) begin : g_c1
         assign eff[c] = legacy_q ? ROUTE_W'(LINE_RTC) : route[c*ROUTE_W +: ROUTE_W];
      end else begin : g_cn
         assign eff[c] = route[c*ROUTE_W +: ROUTE_W];
      end
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic chan_or;
      always_comb begin
         chan_or = 1'b0;
         for (int c = 0; c < NUM_CH; c++)
            if (act[c] && eff[c] == ROUTE_W'(l))
               chan_or = 1'b1;
      end
      if (l == LINE_TICK) begin : g_tick
         assign lines[l] = (enter_q || exit_q) ? 1'b0 : (chan_or | (~legacy_q & tick_q));
      end else if (l == LINE_RTC) begin : g_rtc
         assign lines[l] = enter_q ? 1'b0 :
                           exit_q  ? rtc_q : (chan_or | (~legacy_q & rtc_q));
      end else begin : g_plain
         assign lines[l] = chan_or;
      end
   end
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit #(
   parameter int NUM_CH    = 4,
   parameter int NUM_LINES = 16,
   parameter int ROUTE_W   = $clog2(NUM_LINES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         fire_req,
   input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
   input  logic [NUM_CH-1:0]         ch_level,
   input  logic [NUM_CH-1:0]         ch_en,
   input  logic                      glb_en,
   input  logic                      legacy_mode,
   input  logic                      pit_irq_in,
   input  logic                      rtc_irq_in,
   input  logic                      sts_clr_we,
   input  logic [NUM_CH-1:0]         sts_clr_data,
   output logic [NUM_LINES-1:0]      irq_lines,
   output logic                      pit_en,
   output logic [NUM_CH-1:0]         irq_status
);
   import irq_route_pkg::*;

   if (NUM_LINES < MIN_LINES) begin : g_bad_lines
      $error("irq_route_unit: NUM_LINES must reach line %0d", LINE_RTC);
   end
   if (NUM_CH < MIN_CH) begin : g_bad_ch
      $error("irq_route_unit: at least %0d channels required", MIN_CH);
   end
   if ((1 << ROUTE_W) < NUM_LINES) begin : g_bad_rw
      $error("irq_route_unit: ROUTE_W too narrow");
   end

   logic [NUM_CH-1:0] held, pulse, clr;
   logic legacy_q, enter_q, exit_q, tick_q, rtc_q;

   assign clr = {NUM_CH{sts_clr_we}} & sts_clr_data;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      irq_chan_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .fire     (fire_req[c]),
         .ch_en    (ch_en[c]),
         .glb_en   (glb_en),
         .is_level (ch_level[c]),
         .clr      (clr[c]),
         .held     (held[c]),
         .pulse    (pulse[c])
      );
   end

   irq_legacy_ctl u_leg (
      .clk         (clk),
      .rst_n       (rst_n),
      .legacy_mode (legacy_mode),
      .pit_irq_in  (pit_irq_in),
      .rtc_irq_in  (rtc_irq_in),
      .legacy_q    (legacy_q),
      .enter_q     (enter_q),
      .exit_q      (exit_q),
      .tick_q      (tick_q),
      .rtc_q       (rtc_q)
   );

   irq_line_merge #(
      .NUM_CH    (NUM_CH),
      .NUM_LINES (NUM_LINES),
      .ROUTE_W   (ROUTE_W)
   ) u_merge (
      .act      (held | pulse),
      .route    (ch_route),
      .legacy_q (legacy_q),
      .enter_q  (enter_q),
      .exit_q   (exit_q),
      .tick_q   (tick_q),
      .rtc_q    (rtc_q),
      .lines    (irq_lines)
   );

   assign pit_en     = ~legacy_q;
   assign irq_status = held;

   p_entry_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      enter_q |-> !irq_lines[LINE_TICK] && !irq_lines[LINE_RTC] && !pit_en);
   p_exit_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exit_q |-> !irq_lines[LINE_TICK] && pit_en && (irq_lines[LINE_RTC] == rtc_q));
   p_mode_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_mode |=> !pit_en);
endmodule

// File: tb/tb_irq_route_unit.sv
`timescale 1ns/1ps
module tb_irq_route_unit;
   localparam int NC = 4;
   localparam int NL = 16;
   localparam int RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC-1:0] fire_req = '0, ch_level = '0, ch_en = '0, sts_clr_data = '0;
   logic [NC*RW-1:0] ch_route = '0;
   logic glb_en = 1'b0, legacy_mode = 1'b0, pit_irq_in = 1'b0, rtc_irq_in = 1'b0;
   logic sts_clr_we = 1'b0;
   logic [NL-1:0] irq_lines;
   logic pit_en;
   logic [NC-1:0] irq_status;

   always #4 clk = ~clk;

   irq_route_unit #(.NUM_CH(NC), .NUM_LINES(NL), .ROUTE_W(RW)) dut (
      .clk(clk), .rst_n(rst_n), .fire_req(fire_req), .ch_route(ch_route),
      .ch_level(ch_level), .ch_en(ch_en), .glb_en(glb_en),
      .legacy_mode(legacy_mode), .pit_irq_in(pit_irq_in), .rtc_irq_in(rtc_irq_in),
      .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
      .irq_lines(irq_lines), .pit_en(pit_en), .irq_status(irq_status));

   int checks = 0, errors = 0;
   int m_st[NC], m_pl[NC];
   int m_leg = 0, m_ent = 0, m_ext = 0, m_pit = 0, m_rtc = 0;

   function automatic logic [NL-1:0] exp_lines();
      logic [NL-1:0] v = '0;
      for (int c = 0; c < NC; c++) begin
         int r = int'(ch_route[c*RW +: RW]);
         if (m_leg != 0 && c == 0) r = 0;
         if (m_leg != 0 && c == 1) r = 8;
         if (m_st[c] != 0 || m_pl[c] != 0) v[r] = 1'b1;
      end
      if (m_leg == 0 && m_pit != 0) v[0] = 1'b1;
      if (m_leg == 0 && m_rtc != 0) v[8] = 1'b1;
      if (m_ent != 0) begin v[0] = 1'b0; v[8] = 1'b0; end
      if (m_ext != 0) begin v[0] = 1'b0; v[8] = (m_rtc != 0); end
      return v;
   endfunction

   function automatic logic [NC-1:0] exp_status();
      logic [NC-1:0] s;
      for (int c = 0; c < NC; c++) s[c] = (m_st[c] != 0);
      return s;
   endfunction

   task automatic compare(input string tag);
      logic [NL-1:0] el = exp_lines();
      logic [NC-1:0] es = exp_status();
      logic ep = (m_leg == 0);
      checks++;
      if (irq_lines !== el || irq_status !== es || pit_en !== ep) begin
         errors++;
         $display("FAIL %s: lines=%h status=%b pit_en=%b expected lines=%h status=%b pit_en=%b",
                  tag, irq_lines, irq_status, pit_en, el, es, ep);
      end
   endtask

   // one clock: update the model with the inputs present at the edge, compare after it
   task automatic step(input string tag);
      @(posedge clk);
      for (int c = 0; c < NC; c++) begin
         int acc = fire_req[c] & ch_en[c] & glb_en;
         int clr = sts_clr_we & sts_clr_data[c];
         if (clr != 0) m_st[c] = 0;
         else if (fire_req[c] && acc == 0) m_st[c] = 0;
         else if (acc != 0 && ch_level[c]) m_st[c] = 1;
         m_pl[c] = (acc != 0 && !ch_level[c] && clr == 0) ? 1 : 0;
      end
      m_ent = (legacy_mode && m_leg == 0) ? 1 : 0;
      m_ext = (!legacy_mode && m_leg != 0) ? 1 : 0;
      m_leg = legacy_mode;
      m_pit = pit_irq_in;
      m_rtc = rtc_irq_in;
      @(negedge clk);
      compare(tag);
      fire_req = '0;
      sts_clr_we = 1'b0;
      sts_clr_data = '0;
   endtask

   task automatic set_route(input int c, input int r);
      ch_route[c*RW +: RW] = RW'(r);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) begin m_st[c] = 0; m_pl[c] = 0; end
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      step("R1 after reset");

      set_route(0, 3); set_route(1, 4); set_route(2, 5); set_route(3, 7);
      ch_en = '1; glb_en = 1'b1; ch_level = 4'b0111;

      fire_req[2] = 1'b1; step("R2 level fire");
      step("R2 level hold"); step("R2 level hold");

      sts_clr_we = 1'b1; sts_clr_data = 4'b1011; step("R5 zero bit no effect");
      sts_clr_we = 1'b1; sts_clr_data = 4'b0100; step("R5 clear lowers line");
      fire_req[2] = 1'b1; sts_clr_we = 1'b1; sts_clr_data = 4'b0100;
      step("R5 clear beats fire");

      fire_req[3] = 1'b1; step("R3 edge pulse");
      step("R3 edge pulse ends");
      fire_req[3] = 1'b1; step("R3 edge again"); fire_req[3] = 1'b1; step("R3 back to back");
      step("R3 gone");

      fire_req[0] = 1'b1; step("R2 ch0 set");
      ch_en[0] = 1'b0; fire_req[0] = 1'b1; step("R4 channel disabled fire");
      ch_en[0] = 1'b1; fire_req[1] = 1'b1; step("R2 ch1 set");
      glb_en = 1'b0; fire_req[1] = 1'b1; fire_req[3] = 1'b1; step("R4 global disabled fire");
      glb_en = 1'b1;

      pit_irq_in = 1'b1; step("R7 tick passes");
      rtc_irq_in = 1'b1; step("R7 rtc passes");
      set_route(2, 0); fire_req[2] = 1'b1; step("R10 shared line 0");
      pit_irq_in = 1'b0; step("R10 channel keeps line 0");
      set_route(2, 5); sts_clr_we = 1'b1; sts_clr_data = 4'b0100; step("R5 clear ch2");

      fire_req[0] = 1'b1; fire_req[1] = 1'b1; step("R6 set ch0 ch1");
      pit_irq_in = 1'b1; legacy_mode = 1'b1; step("R8 entry quiet");
      step("R6 legacy routing");
      rtc_irq_in = 1'b0; step("R7 rtc blocked");
      sts_clr_we = 1'b1; sts_clr_data = 4'b0011; step("R7 tick blocked in legacy");
      rtc_irq_in = 1'b1; fire_req[3] = 1'b1; step("R6 other channel keeps route");
      legacy_mode = 1'b0; step("R9 exit restore");
      step("R7 sources back");
      pit_irq_in = 1'b0; rtc_irq_in = 1'b0; step("R7 sources low");

      fire_req[1] = 1'b1; step("R6 ch1 normal route");
      legacy_mode = 1'b1; step("R8 entry with rtc low");
      legacy_mode = 1'b0; step("R9 exit with rtc low");
      step("R6 ch1 back on route");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule